// File: doc/BRIEF.md
# Round-Robin Rotating Priority Grant Selector

This block picks one winner from a vector of N request lines using a rotating priority order. The search starts at the position held in an internal pointer, moves upward through higher indices, and wraps around to index 0 only when no request is found at or above the pointer. It is the selection core of a round-robin arbiter for a switch port scheduler. Each cycle it returns a one-hot grant, a flag that says whether anything won, and the winner's index in binary.

Selection is fully combinational and uses two parallel fixed-priority searches. The first search sees only the requests at or above the pointer, which are picked out with a thermometer mask. The second sees only the requests below the pointer. The OR of the masked upper half chooses which result is used. A pointer register then moves the starting point to one place past each winner, so every requester gets served in turn. N must be a power of two. A parameter chooses between a log-depth prefix network and a ripple prefix inside the fixed-priority searches.

Top module: `rpe_arbiter`

## Requirements
- R1: When any request bit at an index greater than or equal to the pointer is set, grant_o has exactly one bit set. That bit is the lowest-indexed set request bit among those at or above the pointer.
- R2: When no request bit at or above the pointer is set but some bit below it is, grant_o has exactly one bit set. That bit is the lowest-indexed set request bit (the search wraps to index 0).
- R3: When req_i is all zeros, grant_o is all zeros, valid_o is 0 and index_o is 0.
- R4: valid_o is 1 exactly when at least one bit of req_i is 1.
- R5: index_o is the binary position (bit 0 is index 0) of the single set bit of grant_o whenever valid_o is 1.
- R6: While rst_n is low, and on the first cycle after it rises, ptr_o is 0. Reset is asynchronous and active low.
- R7: On a clock edge where valid_o is 1, ptr_o takes the value (index_o + 1) mod N. A grant at index N-1 therefore moves the pointer to 0.
- R8: On a clock edge where valid_o is 0, ptr_o keeps its value.
- R9: A request at the pointer's own position always wins: if req_i[ptr_o] is 1 then grant_o[ptr_o] is 1.
- R10: grant_o never has a bit set where req_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pointer register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N | Request lines, bit k belongs to requester k |
| grant_o | output | N | One-hot grant, all zeros when nothing requests |
| valid_o | output | 1 | Some requester was granted this cycle |
| index_o | output | log2(N) | Binary index of the granted requester |
| ptr_o | output | log2(N) | Current start position of the priority search |

## Verification
The pointer is internal and can only be moved by granting someone, so the hardest thing to reach from the ports is a chosen pairing of pointer value and request pattern. The bench reaches each pointer value on purpose. For a target pointer p it presents a single request at index p-1 (mod N) for one cycle, which moves the pointer to p. It then applies the request vector under test. Doing this for every pointer value and all 256 request vectors of an 8-wide instance covers every (pointer, request) pair, including the wrap from index N-1 to 0. A 32-wide instance runs beside it on sparse and dense random requests.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

   // Structure of the prefix network inside each fixed-priority search
   typedef enum logic {
      PFX_CHAIN = 1'b0,
      PFX_TREE  = 1'b1
   } rpe_prefix_e;

   function automatic bit is_pow2(input int value);
      return (value >= 2) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/rpe_thermo_mask.sv
// Thermometer mask: bit j is set when j is at or above the pointer.
module rpe_thermo_mask #(
   parameter  int N  = 32,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [PW-1:0] ptr_i,
   output logic [N-1:0]  mask_o
);

   always_comb begin
      for (int j = 0; j < N; j++) begin
         mask_o[j] = (j >= int'(ptr_i));
      end
   end

endmodule

// File: rtl/rpe_fixed_pe.sv
// Fixed-priority search: the lowest set input bit wins, result is one-hot.
module rpe_fixed_pe
   import rpe_pkg::*;
#(
   parameter int          N      = 32,
   parameter rpe_prefix_e PREFIX = PFX_TREE,
   localparam int         PW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] in_i,
   output logic [N-1:0] onehot_o,
   output logic         any_o
);

   generate
      if (PREFIX == PFX_TREE) begin : g_tree
         // Log-depth inclusive prefix OR of the lower bits
         always_comb begin
            logic [N-1:0] pre;
            pre = in_i;
            for (int s = 0; s < PW; s++) begin
               pre = pre | (pre << (1 << s));
            end
            onehot_o = in_i & ~(pre << 1);
            any_o    = pre[N-1];
         end
      end else begin : g_chain
         // Linear running prefix, one gate per position
         always_comb begin
            logic seen;
            seen = 1'b0;
            for (int j = 0; j < N; j++) begin
               onehot_o[j] = in_i[j] & ~seen;
               seen        = seen | in_i[j];
            end
            any_o = seen;
         end
      end
   endgenerate

endmodule

// File: rtl/rpe_onehot_enc.sv
// One-hot to binary index encoder (OR of the indices of the set bits).
module rpe_onehot_enc #(
   parameter  int N  = 32,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  onehot_i,
   output logic [PW-1:0] index_o
);

   always_comb begin
      index_o = '0;
      for (int j = 0; j < N; j++) begin
         if (onehot_i[j]) begin
            index_o = index_o | PW'(j);
         end
      end
   end

endmodule

// File: rtl/rpe_core.sv
// Combinational rotating-priority select: upper-half search, lower-half search, 2:1 pick.
module rpe_core
   import rpe_pkg::*;
#(
   parameter int          N      = 32,
   parameter rpe_prefix_e PREFIX = PFX_TREE,
   localparam int         PW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   input  logic [PW-1:0] ptr_i,
   output logic [N-1:0]  grant_o,
   output logic          valid_o,
   output logic [PW-1:0] index_o
);

   logic [N-1:0] mask_w;
   logic [N-1:0] upper_w;
   logic [N-1:0] lower_w;
   logic [N-1:0] pick_hi_w;
   logic [N-1:0] pick_lo_w;
   logic         any_hi_w;
   logic         any_lo_w;

   rpe_thermo_mask #(.N(N)) u_mask (
      .ptr_i  (ptr_i),
      .mask_o (mask_w)
   );

   assign upper_w = req_i & mask_w;
   assign lower_w = req_i & ~mask_w;

   rpe_fixed_pe #(.N(N), .PREFIX(PREFIX)) u_pe_hi (
      .in_i     (upper_w),
      .onehot_o (pick_hi_w),
      .any_o    (any_hi_w)
   );

   rpe_fixed_pe #(.N(N), .PREFIX(PREFIX)) u_pe_lo (
      .in_i     (lower_w),
      .onehot_o (pick_lo_w),
      .any_o    (any_lo_w)
   );

   assign grant_o = any_hi_w ? pick_hi_w : pick_lo_w;
   assign valid_o = any_hi_w | any_lo_w;

   rpe_onehot_enc #(.N(N)) u_enc (
      .onehot_i (grant_o),
      .index_o  (index_o)
   );

endmodule

// File: rtl/rpe_arbiter.sv
// Round-robin arbiter: rotating-priority core plus a pointer that advances past each winner.
module rpe_arbiter
   import rpe_pkg::*;
#(
   parameter int          N      = 32,
   parameter rpe_prefix_e PREFIX = PFX_TREE,
   localparam int         PW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  grant_o,
   output logic          valid_o,
   output logic [PW-1:0] index_o,
   output logic [PW-1:0] ptr_o
);

   generate
      if (!is_pow2(N)) begin : g_bad_n
         $error("rpe_arbiter: N must be a power of two and at least 2");
      end
   endgenerate

   logic [PW-1:0] ptr_q;

   rpe_core #(.N(N), .PREFIX(PREFIX)) u_core (
      .req_i   (req_i),
      .ptr_i   (ptr_q),
      .grant_o (grant_o),
      .valid_o (valid_o),
      .index_o (index_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (valid_o) begin
         ptr_q <= index_o + PW'(1);
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/rpe_arbiter_chk.sv
// Property checker for rpe_arbiter, attached by bind.
module rpe_arbiter_chk #(
   parameter  int N  = 32,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  req_i,
   input logic [N-1:0]  grant_o,
   input logic          valid_o,
   input logic [PW-1:0] index_o,
   input logic [PW-1:0] ptr_o
);

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   assert_grant_in_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0);

   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> (grant_o == '0 && index_o == '0));

   assert_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == (req_i != '0));

   assert_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> grant_o[index_o]);

   assert_ptr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> (ptr_o == PW'($past(index_o) + PW'(1))));

   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |=> $stable(ptr_o));

   assert_ptr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[ptr_o] |-> grant_o[ptr_o]);

endmodule

bind rpe_arbiter rpe_arbiter_chk #(.N(N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .grant_o (grant_o),
   .valid_o (valid_o),
   .index_o (index_o),
   .ptr_o   (ptr_o)
);

// File: tb/rpe_arbiter_bench.sv
`timescale 1ns/1ps
module rpe_arbiter_bench;
   import rpe_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [7:0]  req8 = '0;
   logic [7:0]  g8;
   logic        v8;
   logic [2:0]  i8, p8;
   logic [31:0] req32 = '0;
   logic [31:0] g32;
   logic        v32;
   logic [4:0]  i32, p32;

   rpe_arbiter #(.N(8), .PREFIX(PFX_TREE)) u_rpe_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req8),
      .grant_o(g8), .valid_o(v8), .index_o(i8), .ptr_o(p8));

   rpe_arbiter #(.N(32), .PREFIX(PFX_CHAIN)) u_rpe_arbiter_w32 (
      .clk(clk), .rst_n(rst_n), .req_i(req32),
      .grant_o(g32), .valid_o(v32), .index_o(i32), .ptr_o(p32));

   int n_cmp = 0;
   int n_bad = 0;
   int mptr8 = 0;
   int mptr32 = 0;
   string ptag8 = "R6";
   string ptag32 = "R6";

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected winner: scan upward from p with wrap; -1 when nothing requests
   function automatic int exp_pos(input logic [31:0] r, input int p, input int n);
      for (int k = 0; k < n; k++) begin
         int pos = (p + k) % n;
         if (r[pos]) return pos;
      end
      return -1;
   endfunction

   function automatic string grant_tag(input logic [31:0] r, input int p, input int n);
      if (r == 0) return "R3";
      if (r[p]) return "R9";
      for (int k = p; k < n; k++) if (r[k]) return "R1";
      return "R2";
   endfunction

   // Sample both instances mid-low-phase, then advance the model pointers
   task automatic sample();
      int w8, w32;
      longint eg8, eg32;
      #5;
      chk(ptag8, p8, mptr8);
      chk(ptag32, p32, mptr32);
      w8  = exp_pos({24'd0, req8}, mptr8, 8);
      w32 = exp_pos(req32, mptr32, 32);
      eg8  = (w8 < 0) ? 0 : (longint'(1) << w8);
      eg32 = (w32 < 0) ? 0 : (longint'(1) << w32);
      chk(grant_tag({24'd0, req8}, mptr8, 8), g8, eg8);
      chk(grant_tag(req32, mptr32, 32), g32, eg32);
      chk("R4", v8, (w8 >= 0));
      chk("R4", v32, (w32 >= 0));
      chk((w8 < 0) ? "R3" : "R5", i8, (w8 < 0) ? 0 : w8);
      chk((w32 < 0) ? "R3" : "R5", i32, (w32 < 0) ? 0 : w32);
      if (rst_n) begin
         if (w8 >= 0) begin mptr8 = (w8 + 1) % 8; ptag8 = "R7"; end
         else ptag8 = "R8";
         if (w32 >= 0) begin mptr32 = (w32 + 1) % 32; ptag32 = "R7"; end
         else ptag32 = "R8";
      end
   endtask

   task automatic step(input logic [7:0] r8, input int mode);
      logic [31:0] r;
      @(negedge clk);
      req8 = r8;
      r = $urandom;
      case (mode % 4)
         0: req32 = r & $urandom & $urandom;
         1: req32 = r;
         2: req32 = 32'd1 << (r % 32);
         default: req32 = (mode % 16 == 3) ? 32'd0 : (r & $urandom);
      endcase
      sample();
   endtask

   initial begin : watchdog
      #(20ns * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      // Reset state: pointer 0, idle outputs (R6, R3)
      repeat (2) begin
         @(negedge clk);
         req8 = '0; req32 = '0;
         sample();
      end
      @(negedge clk);
      rst_n = 1'b1;
      req8 = '0; req32 = '0;
      sample();   // R6: pointer still 0 after reset release
      // Grant at N-1 must wrap the pointer to 0 (R7)
      step(8'h80, 2);
      step(8'h00, 3);
      // Every pointer value against every request vector of the 8-wide instance
      for (int p = 0; p < 8; p++) begin
         for (int v = 0; v < 256; v++) begin
            step(8'd1 << ((p + 7) % 8), v);   // steer pointer to p
            step(v[7:0], v + 1);
         end
      end
      // Idle stretch: pointer must hold (R8)
      for (int k = 0; k < 4; k++) step(8'h00, 3 + 16 * k);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule